// File: doc/BRIEF.md
# SAR Converter Track-and-Convert Sequencer

This block is the digital timing controller of a 10-bit successive-approximation converter. A 3-bit trigger-mode code selects one start source: a software start strobe, one of four timer-overflow strobes, or an external convert-start pin. Once a start is accepted, the block runs the conversion one SAR clock per cycle. It drives the trial code to the converter DAC and reads the external comparator once per bit. At the end it loads the result register, drops busy and pulses done.

The sampling switch is controlled by `track_en`. Two tracking policies are available. In continuous mode the input is tracked whenever no conversion is running. In low-power mode there are two cases. With an internal source, tracking runs only for a fixed window of 3 SAR clocks after the start. With the pin source, tracking runs only while the pin is low, and the conversion starts on its rising edge. A sleep input turns tracking off in every mode.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `result` and `dac_code` are all 0.
- R2: The trigger-mode code maps to start sources as follows:
  - 000 selects `sw_start`.
  - 001, 010 and 011 select `tmr_ovf[0]`, `tmr_ovf[1]` and `tmr_ovf[2]`.
  - 101 selects `tmr_ovf[3]`.
  - 100 selects a rising edge of `cnv_pin`.
  - 110 and 111 select no source.
  - Strobes from sources that are not selected start nothing.
- R3: With `lp_track`=0 and `sleep`=0, `track_en` equals the inverse of `busy`. A conversion keeps `busy` high for exactly 11 cycles.
- R4: With `lp_track`=1 and an internal source, `busy` stays high for 14 cycles. `track_en` is high in exactly the first 3 of those cycles and low while idle.
- R5: With `lp_track`=1 and the pin source, `track_en` is high while idle only when the pin is low. The conversion starts on the pin's rising edge and keeps `busy` high for 11 cycles with `track_en` low.
- R6: While `sleep`=1, `track_en` is 0 in every mode and state. Conversions still complete.
- R7: The conversion is 1 setup cycle followed by 10 bit trials, MSB first. The first trial code is 512. A trial bit is kept when `cmp_in`=1 (input at or above the trial code) and cleared otherwise. So an ideal comparator yields the input value.
- R8: `busy` rises in the cycle after an accepted start. `done` is a single-cycle pulse in the cycle where `busy` first reads 0, and `result` holds the new value in that cycle.
- R9: Start strobes and pin edges that arrive while `busy` is high are ignored. The running conversion keeps its length and result, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SAR clock, one tick per conversion step |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_mode | input | 3 | Start-source select code |
| lp_track | input | 1 | 1 = low-power tracking, 0 = continuous tracking |
| sleep | input | 1 | Standby request, forces tracking off |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer-overflow strobes 0..3 |
| cnv_pin | input | 1 | External convert-start pin |
| cmp_in | input | 1 | Comparator: 1 when input is at or above DAC level |
| track_en | output | 1 | Sampling switch closed (tracking) |
| dac_code | output | 10 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is loaded |
| result | output | 10 | Last conversion result |

## Verification
Conversions are run from every valid mode code with both tracking policies, sleep on and off, and random input levels. The extremes 0, 1023, 511 and 512 are also used, because they separate a wrong keep/clear rule or a wrong trial order from the correct MSB-first search. Each mode is also given strobes from every source it does not select. This shows whether the decode mixes up the timer mapping, in particular the skipped code 100 before timer 3. Some conversions receive extra strobes and a fresh pin edge mid-run. These tell a design that ignores retriggers from one that restarts or chains conversions, which shows up in the busy length and in done.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRACK = 2'd1,
      ST_SETUP = 2'd2,
      ST_TRIAL = 2'd3
   } seq_state_e;

   localparam logic [2:0] MODE_SW  = 3'b000;
   localparam logic [2:0] MODE_T0  = 3'b001;
   localparam logic [2:0] MODE_T1  = 3'b010;
   localparam logic [2:0] MODE_T2  = 3'b011;
   localparam logic [2:0] MODE_PIN = 3'b100;
   localparam logic [2:0] MODE_T3  = 3'b101;

endpackage

// File: rtl/sar_trig_sel.sv
module sar_trig_sel #(
   parameter int NUM_TIMERS  = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            mode,
   input  logic                  sw_start,
   input  logic [NUM_TIMERS-1:0] tmr_ovf,
   input  logic                  cnv_pin,
   output logic                  start,
   output logic                  ext_sel,
   output logic                  pin_lvl
);
   import sar_seq_pkg::*;

   if (NUM_TIMERS != 4) begin : g_bad_timers
      $error("sar_trig_sel: mode decode needs exactly 4 timer strobes");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("sar_trig_sel: SYNC_STAGES must not be negative");
   end

   logic pin_s;
   logic pin_q;

   generate
      if (SYNC_STAGES == 0) begin : g_raw
         assign pin_s = cnv_pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= cnv_pin;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign pin_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   // Resets high so a pin held high through reset is not taken as an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_s;
   end

   assign pin_lvl = pin_s;
   assign ext_sel = (mode == MODE_PIN);

   always_comb begin
      unique case (mode)
         MODE_SW:  start = sw_start;
         MODE_T0:  start = tmr_ovf[0];
         MODE_T1:  start = tmr_ovf[1];
         MODE_T2:  start = tmr_ovf[2];
         MODE_T3:  start = tmr_ovf[3];
         MODE_PIN: start = pin_s & ~pin_q;
         default:  start = 1'b0;
      endcase
   end

   AST_NO_START_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2:1] == 2'b11) |-> !start) else $error("reserved mode started");  // R2

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int RES_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_msb,
   input  logic             step,
   input  logic             cmp_in,
   output logic [RES_W-1:0] code,
   output logic [RES_W-1:0] code_nxt,
   output logic             last
);
   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] code_q;
   logic [RES_W-1:0] mask_q;

   // Keep the trial bit when the input is at or above the trial level.
   assign code_nxt = (cmp_in ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= '0;
      end else if (load_msb) begin
         code_q <= MSB_ONLY;
         mask_q <= MSB_ONLY;
      end else if (step) begin
         code_q <= code_nxt;
         mask_q <= mask_q >> 1;
      end
   end

   assign code = code_q;
   assign last = mask_q[0];

   AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q)) else $error("trial mask not one-hot");  // R7
   AST_STEP_HAS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (mask_q != '0)) else $error("trial step with no bit");  // R7
   AST_SETUP_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      load_msb |=> (code_q == MSB_ONLY)) else $error("first trial not MSB");  // R7

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
   parameter int RES_W       = 10,
   parameter int NUM_TIMERS  = 4,
   parameter int TRACK_CLKS  = 3,
   parameter int SYNC_STAGES = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            trig_mode,
   input  logic                  lp_track,
   input  logic                  sleep,
   input  logic                  sw_start,
   input  logic [NUM_TIMERS-1:0] tmr_ovf,
   input  logic                  cnv_pin,
   input  logic                  cmp_in,
   output logic                  track_en,
   output logic [RES_W-1:0]      dac_code,
   output logic                  busy,
   output logic                  done,
   output logic [RES_W-1:0]      result
);
   import sar_seq_pkg::*;

   localparam int TCW = (TRACK_CLKS < 2) ? 1 : $clog2(TRACK_CLKS);
   localparam logic [TCW-1:0] TRK_LOAD = TCW'(TRACK_CLKS - 1);

   if (RES_W < 2) begin : g_bad_res
      $error("sar_seq_top: RES_W must be at least 2");
   end
   if (TRACK_CLKS < 1) begin : g_bad_track
      $error("sar_seq_top: TRACK_CLKS must be at least 1");
   end

   seq_state_e       state_q;
   logic [TCW-1:0]   trk_cnt_q;
   logic             busy_q;
   logic             done_q;
   logic [RES_W-1:0] result_q;
   logic             start;
   logic             ext_sel;
   logic             pin_lvl;
   logic             last;
   logic [RES_W-1:0] code_nxt;

   sar_trig_sel #(
      .NUM_TIMERS  (NUM_TIMERS),
      .SYNC_STAGES (SYNC_STAGES)
   ) trig_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (trig_mode),
      .sw_start (sw_start),
      .tmr_ovf  (tmr_ovf),
      .cnv_pin  (cnv_pin),
      .start    (start),
      .ext_sel  (ext_sel),
      .pin_lvl  (pin_lvl)
   );

   sar_trial_reg #(
      .RES_W (RES_W)
   ) trial_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_msb (state_q == ST_SETUP),
      .step     (state_q == ST_TRIAL),
      .cmp_in   (cmp_in),
      .code     (dac_code),
      .code_nxt (code_nxt),
      .last     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         trk_cnt_q <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         result_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  busy_q <= 1'b1;
                  if (lp_track && !ext_sel) begin
                     state_q   <= ST_TRACK;
                     trk_cnt_q <= TRK_LOAD;
                  end else begin
                     state_q <= ST_SETUP;
                  end
               end
            end
            ST_TRACK: begin
               if (trk_cnt_q == '0) state_q   <= ST_SETUP;
               else                 trk_cnt_q <= trk_cnt_q - 1'b1;
            end
            ST_SETUP: state_q <= ST_TRIAL;
            ST_TRIAL: begin
               if (last) begin
                  state_q  <= ST_IDLE;
                  busy_q   <= 1'b0;
                  done_q   <= 1'b1;
                  result_q <= code_nxt;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (sleep)         track_en = 1'b0;
      else if (!lp_track) track_en = (state_q == ST_IDLE);
      else if (ext_sel)  track_en = (state_q == ST_IDLE) && !pin_lvl;
      else               track_en = (state_q == ST_TRACK);
   end

   assign busy   = busy_q;
   assign done   = done_q;
   assign result = result_q;

   AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !track_en) else $error("tracking during sleep");  // R6
   AST_CONT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!lp_track && !sleep) |-> (track_en == !busy)) else $error("continuous tracking broken");  // R3
   AST_TRACK_WINDOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TRACK) |-> busy) else $error("track window outside busy");  // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle");  // R8
   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))) else $error("done without busy fall");  // R8
   AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done)) else $error("busy dropped without done");  // R9

endmodule

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] trig_mode = 3'b000;
   logic       lp_track = 1'b0;
   logic       sleep = 1'b0;
   logic       sw_start = 1'b0;
   logic [3:0] tmr_ovf = 4'b0;
   logic       cnv_pin = 1'b0;
   logic       cmp_in;
   logic       track_en;
   logic [9:0] dac_code;
   logic       busy;
   logic       done;
   logic [9:0] result;
   int         vin = 0;
   int         n_checks = 0;
   int         n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Ideal comparator model: 1 when the input is at or above the DAC level.
   assign cmp_in = (vin >= int'(dac_code));

   sar_seq_top dut_i (
      .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .lp_track(lp_track),
      .sleep(sleep), .sw_start(sw_start), .tmr_ovf(tmr_ovf), .cnv_pin(cnv_pin),
      .cmp_in(cmp_in), .track_en(track_en), .dac_code(dac_code), .busy(busy),
      .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   // Source index: 0 = software, 1..4 = timer 0..3, 5 = pin, 6 = none (R2)
   function automatic int src_of(input logic [2:0] m);
      case (m)
         3'b000: return 0;
         3'b001: return 1;
         3'b010: return 2;
         3'b011: return 3;
         3'b101: return 4;
         3'b100: return 5;
         default: return 6;
      endcase
   endfunction

   // Expected SAR search, MSB first, keep bit when input >= trial (R7)
   function automatic int sar_expect(input int v);
      int c = 0;
      for (int b = 9; b >= 0; b--) begin
         if (v >= (c | (1 << b))) c = c | (1 << b);
      end
      return c;
   endfunction

   task automatic pulse_src(input int s);
      if (s == 0) sw_start = 1'b1;
      else if (s >= 1 && s <= 4) tmr_ovf[s-1] = 1'b1;
   endtask

   task automatic run_conv(input logic [2:0] m, input bit lp, input bit slp,
                           input int v, input bit inj);
      int  s = src_of(m);
      bit  ext = (s == 5);
      int  trk = (lp && !ext) ? 3 : 0;
      int  k = 0;
      int  bad_trk = 0;
      tick();
      trig_mode = m; lp_track = lp; sleep = slp; vin = v; cnv_pin = 1'b0;
      tick();
      chk(busy == 1'b0, "R8 idle busy", busy, 0);
      if (slp) chk(track_en == 1'b0, "R6 idle sleep track", track_en, 0);
      else if (!lp) chk(track_en == 1'b1, "R3 idle track", track_en, 1);
      else if (ext) chk(track_en == 1'b1, "R5 pin low track", track_en, 1);
      else chk(track_en == 1'b0, "R4 lp idle track", track_en, 0);
      if (ext) cnv_pin = 1'b1; else pulse_src(s);
      forever begin
         tick();
         sw_start = 1'b0; tmr_ovf = '0;
         if (!busy) break;
         k++;
         if (track_en != ((!slp && trk > 0 && k <= 3) ? 1'b1 : 1'b0)) bad_trk++;
         if (k == trk + 2) chk(dac_code == 10'd512, "R7 first trial", dac_code, 512);
         if (inj && k == 4) cnv_pin = 1'b0;
         if (inj && k == 5) begin
            cnv_pin = 1'b1; sw_start = 1'b1; tmr_ovf = 4'hF;
         end
         if (k > 40) break;
      end
      chk(bad_trk == 0, lp ? "R4 track window" : "R3 track in conv", bad_trk, 0);
      chk(k == 11 + trk, trk > 0 ? "R4 busy length" : "R3 busy length", k, 11 + trk);
      chk(done == 1'b1, "R8 done at busy fall", done, 1);
      chk(int'(result) == sar_expect(v), "R7 result", result, sar_expect(v));
      tick();
      chk(done == 1'b0 && busy == 1'b0, "R9 single conversion", {busy, done}, 0);
      if (lp && ext && !slp) chk(track_en == 1'b0, "R5 pin high no track", track_en, 0);
   endtask

   task automatic no_start(input logic [2:0] m);
      int s = src_of(m);
      tick();
      trig_mode = m; cnv_pin = 1'b0;
      tick();
      for (int q = 0; q < 5; q++) if (q != s) pulse_src(q);
      if (s != 5) cnv_pin = 1'b1;
      tick();
      sw_start = 1'b0; tmr_ovf = '0;
      tick();
      chk(busy == 1'b0, "R2 wrong source ignored", busy, 0);
      cnv_pin = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] modes [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101, 3'b100};
      void'($urandom(32'd1971));
      repeat (4) tick();
      chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
      chk(result == 0 && dac_code == 0, "R1 reset data", result, 0);
      rst_n = 1'b1;
      tick();
      // Directed: every source, both policies, edge values
      for (int i = 0; i < 6; i++) run_conv(modes[i], 1'b0, 1'b0, 1023 - i * 100, 1'b0);
      for (int i = 0; i < 6; i++) run_conv(modes[i], 1'b1, 1'b0, i * 97, 1'b0);
      run_conv(3'b000, 1'b0, 1'b0, 0, 1'b0);
      run_conv(3'b101, 1'b1, 1'b0, 1023, 1'b0);
      run_conv(3'b001, 1'b0, 1'b0, 512, 1'b1);
      run_conv(3'b100, 1'b1, 1'b0, 511, 1'b1);
      run_conv(3'b010, 1'b1, 1'b1, 300, 1'b0);
      run_conv(3'b100, 1'b1, 1'b1, 700, 1'b0);
      // Wrong-source and reserved codes (R2)
      for (int i = 0; i < 6; i++) no_start(modes[i]);
      no_start(3'b110);
      no_start(3'b111);
      // Sleep forces tracking off while idle (R6)
      tick();
      lp_track = 1'b0; sleep = 1'b1;
      tick();
      chk(track_en == 1'b0, "R6 sleep idle", track_en, 0);
      sleep = 1'b0;
      // Constrained random
      for (int n = 0; n < 40; n++) begin
         run_conv(modes[$urandom % 6], 1'($urandom % 2), ($urandom % 5) == 0,
                  int'($urandom % 1024), ($urandom % 4) == 0);
      end
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule